// File: doc/BRIEF.md
# Parallel RGB LCD Timing Generator

This block produces the scan timing for a small 480x272 parallel-RGB LCD panel from a fast system clock. It derives a slow pixel clock from a tick counter running on the system clock, and once per pixel-clock period it advances a column counter and, at a fixed column, a row counter. From these two positions it decodes active-low horizontal and vertical sync strobes and a data-enable. It also passes three 6-bit colour channels to the panel, forcing them to zero outside the visible area.

The pixel clock has two ratios, picked by a static input that is changed only while reset is held. The odd ratio divides by 11 with 5 ticks high and 6 low. This gives about 9.09 MHz from 100 MHz, inside the panel's accepted 7.83 to 9.26 MHz band. The even ratio divides by 12 with an exact half duty, about 8.33 MHz. The raster is 525 pixel clocks by 286 lines. Sync placement and the line advance follow the panel's timing rather than any broadcast standard.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst` is high, at the next clock edge the column and row become 0, `lcd_pclk` is 0, and both sync outputs are 1.
- R2: With `div_even` = 0, `lcd_pclk` first rises 11 system clocks after reset is released. It then repeats with a period of 11 system clocks, 5 high and 6 low.
- R3: With `div_even` = 1, `lcd_pclk` first rises 12 system clocks after reset is released. It then repeats with a period of 12, 6 high and 6 low.
- R4: The column advances by exactly one once per pixel-clock period. This happens on the second system clock edge after reset release and then at the same phase of every later period.
- R5: The column runs 0 to 524 and returns to 0 after 524, so a line is 525 pixel clocks long.
- R6: `lcd_hsync_n` is 0 exactly while the column is between 482 and 523 inclusive.
- R7: The row changes only on the column step that leaves column 499. It goes up by one there, or returns to 0 when it has reached 285, giving 286 lines.
- R8: `lcd_vsync_n` is 0 exactly while the row is between 274 and 283 inclusive.
- R9: `lcd_de` is 1 exactly when the column is below 480 and the row is below 272.
- R10: Each colour output equals its input while `lcd_de` is 1, and is 0 while `lcd_de` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_even | input | 1 | Pixel clock ratio: 0 = divide by 11, 1 = divide by 12; changed only during reset |
| red_in | input | 6 | Red pixel value for the current position |
| grn_in | input | 6 | Green pixel value for the current position |
| blu_in | input | 6 | Blue pixel value for the current position |
| lcd_pclk | output | 1 | Pixel clock to the panel |
| lcd_hsync_n | output | 1 | Horizontal sync, active low |
| lcd_vsync_n | output | 1 | Vertical sync, active low |
| lcd_de | output | 1 | High inside the visible 480x272 area |
| pix_col | output | 10 | Current column count |
| pix_row | output | 9 | Current row count |
| lcd_red | output | 6 | Red to panel, zero when blanked |
| lcd_grn | output | 6 | Green to panel, zero when blanked |
| lcd_blu | output | 6 | Blue to panel, zero when blanked |

## Verification
A wrong tick count shows up within one pixel-clock period, no more than a dozen system clocks. It appears as a misplaced `lcd_pclk` edge and a column step at the wrong cycle. A wrong column count or wrap is visible at once on `pix_col`, and within one line on the sync and data-enable edges. A wrong row advance shows on `pix_row` at the next column-499 step. A reduced-raster instance runs beside the full-size one so that vertical wrap and the vertical sync window are reached within a few thousand cycles.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int TICK_W = 4;

    // last tick index and last high tick index for each divider ratio
    localparam logic [TICK_W-1:0] ODD_LAST       = 4'd10;
    localparam logic [TICK_W-1:0] ODD_HIGH_LAST  = 4'd4;
    localparam logic [TICK_W-1:0] EVEN_LAST      = 4'd11;
    localparam logic [TICK_W-1:0] EVEN_HIGH_LAST = 4'd5;

    typedef enum logic {
        DIV_ODD11  = 1'b0,
        DIV_EVEN12 = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              pclk;
    } div_state_t;

endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div
    import lcd_tg_pkg::*;
#(
    parameter int STEP_PHASE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic div_even,
    output logic pclk,
    output logic step
);

    localparam logic [TICK_W-1:0] STEP_AT = TICK_W'(STEP_PHASE);

    div_state_t        st_d, st_q;
    div_mode_e         mode;
    logic [TICK_W-1:0] last_tick;
    logic [TICK_W-1:0] high_last;

    always_comb begin
        mode      = div_mode_e'(div_even);
        last_tick = (mode == DIV_EVEN12) ? EVEN_LAST : ODD_LAST;
        high_last = (mode == DIV_EVEN12) ? EVEN_HIGH_LAST : ODD_HIGH_LAST;
        st_d      = st_q;
        if (st_q.tick >= last_tick) begin
            st_d.tick = '0;
            st_d.pclk = 1'b1;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
            if (st_q.tick == high_last) begin
                st_d.pclk = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pclk = st_q.pclk;
    assign step = (st_q.tick == STEP_AT);

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
    parameter int TOTAL      = 525,
    parameter int ACTIVE     = 480,
    parameter int SYNC_FIRST = 482,
    parameter int SYNC_LAST  = 523,
    parameter int CW         = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          sync_n
);

    localparam logic [CW-1:0] LAST_C  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] ACT_C   = CW'(ACTIVE);
    localparam logic [CW-1:0] SFIRST_C = CW'(SYNC_FIRST);
    localparam logic [CW-1:0] SLAST_C  = CW'(SYNC_LAST);

    typedef struct packed {
        logic [CW-1:0] pos;
    } axis_state_t;

    axis_state_t ax_d, ax_q;

    always_comb begin
        ax_d = ax_q;
        if (adv) begin
            if (ax_q.pos >= LAST_C) begin
                ax_d.pos = '0;
            end else begin
                ax_d.pos = ax_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ax_q <= '0;
        end else begin
            ax_q <= ax_d;
        end
    end

    assign cnt    = ax_q.pos;
    assign active = (ax_q.pos < ACT_C);
    assign sync_n = !((ax_q.pos >= SFIRST_C) && (ax_q.pos <= SLAST_C));

endmodule

// File: rtl/lcd_pix_gate.sv
module lcd_pix_gate #(
    parameter int COLOR_W = 6,
    parameter int NCH     = 3
) (
    input  logic                     de,
    input  logic [NCH*COLOR_W-1:0]   din,
    output logic [NCH*COLOR_W-1:0]   dout
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign dout[c*COLOR_W +: COLOR_W] = de ? din[c*COLOR_W +: COLOR_W] : '0;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
    parameter int H_TOTAL      = 525,
    parameter int H_ACTIVE     = 480,
    parameter int HS_FIRST     = 482,
    parameter int HS_LAST      = 523,
    parameter int ROW_STEP_COL = 499,
    parameter int V_TOTAL      = 286,
    parameter int V_ACTIVE     = 272,
    parameter int VS_FIRST     = 274,
    parameter int VS_LAST      = 283,
    parameter int STEP_PHASE   = 1,
    parameter int COLOR_W      = 6,
    parameter int COL_W        = $clog2(H_TOTAL),
    parameter int ROW_W        = $clog2(V_TOTAL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               div_even,
    input  logic [COLOR_W-1:0] red_in,
    input  logic [COLOR_W-1:0] grn_in,
    input  logic [COLOR_W-1:0] blu_in,
    output logic               lcd_pclk,
    output logic               lcd_hsync_n,
    output logic               lcd_vsync_n,
    output logic               lcd_de,
    output logic [COL_W-1:0]   pix_col,
    output logic [ROW_W-1:0]   pix_row,
    output logic [COLOR_W-1:0] lcd_red,
    output logic [COLOR_W-1:0] lcd_grn,
    output logic [COLOR_W-1:0] lcd_blu
);

    localparam int NCH = 3;
    localparam logic [COL_W-1:0] ROW_STEP_C = COL_W'(ROW_STEP_COL);

    logic px_step;
    logic row_adv;
    logic h_act;
    logic v_act;
    logic [NCH*COLOR_W-1:0] pix_in;
    logic [NCH*COLOR_W-1:0] pix_out;

    lcd_pclk_div #(
        .STEP_PHASE(STEP_PHASE)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_even(div_even),
        .pclk    (lcd_pclk),
        .step    (px_step)
    );

    lcd_axis_ctr #(
        .TOTAL     (H_TOTAL),
        .ACTIVE    (H_ACTIVE),
        .SYNC_FIRST(HS_FIRST),
        .SYNC_LAST (HS_LAST),
        .CW        (COL_W)
    ) u_hax (
        .clk   (clk),
        .rst   (rst),
        .adv   (px_step),
        .cnt   (pix_col),
        .active(h_act),
        .sync_n(lcd_hsync_n)
    );

    assign row_adv = px_step && (pix_col == ROW_STEP_C);

    lcd_axis_ctr #(
        .TOTAL     (V_TOTAL),
        .ACTIVE    (V_ACTIVE),
        .SYNC_FIRST(VS_FIRST),
        .SYNC_LAST (VS_LAST),
        .CW        (ROW_W)
    ) u_vax (
        .clk   (clk),
        .rst   (rst),
        .adv   (row_adv),
        .cnt   (pix_row),
        .active(v_act),
        .sync_n(lcd_vsync_n)
    );

    assign lcd_de = h_act & v_act;
    assign pix_in = {blu_in, grn_in, red_in};

    lcd_pix_gate #(
        .COLOR_W(COLOR_W),
        .NCH    (NCH)
    ) u_gate (
        .de  (lcd_de),
        .din (pix_in),
        .dout(pix_out)
    );

    assign lcd_red = pix_out[0*COLOR_W +: COLOR_W];
    assign lcd_grn = pix_out[1*COLOR_W +: COLOR_W];
    assign lcd_blu = pix_out[2*COLOR_W +: COLOR_W];

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
    parameter int H_TOTAL      = 525,
    parameter int HS_FIRST     = 482,
    parameter int HS_LAST      = 523,
    parameter int ROW_STEP_COL = 499,
    parameter int VS_FIRST     = 274,
    parameter int COLOR_W      = 6,
    parameter int COL_W        = 10,
    parameter int ROW_W        = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               lcd_pclk,
    input logic               lcd_hsync_n,
    input logic               lcd_vsync_n,
    input logic               lcd_de,
    input logic [COL_W-1:0]   pix_col,
    input logic [ROW_W-1:0]   pix_row,
    input logic [COLOR_W-1:0] lcd_red,
    input logic [COLOR_W-1:0] lcd_grn,
    input logic [COLOR_W-1:0] lcd_blu
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pix_col == '0 && pix_row == '0 && !lcd_pclk && lcd_hsync_n && lcd_vsync_n));

    assert_col_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pix_col != $past(pix_col)) |->
            (pix_col == $past(pix_col) + COL_W'(1)) ||
            (pix_col == '0 && $past(pix_col) == COL_W'(H_TOTAL - 1)));

    assert_hsync_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_hsync_n) |-> (pix_col == COL_W'(HS_FIRST)));

    assert_hsync_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_hsync_n) |-> (pix_col == COL_W'(HS_LAST + 1)));

    assert_row_step_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_row != $past(pix_row)) |-> ($past(pix_col) == COL_W'(ROW_STEP_COL)));

    assert_vsync_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_vsync_n) |-> (pix_row == ROW_W'(VS_FIRST)));

    assert_blank_R10: assert property (@(posedge clk) disable iff (rst)
        !lcd_de |-> (lcd_red == '0 && lcd_grn == '0 && lcd_blu == '0));

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(
    .H_TOTAL     (H_TOTAL),
    .HS_FIRST    (HS_FIRST),
    .HS_LAST     (HS_LAST),
    .ROW_STEP_COL(ROW_STEP_COL),
    .VS_FIRST    (VS_FIRST),
    .COLOR_W     (COLOR_W),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lcd_pclk   (lcd_pclk),
    .lcd_hsync_n(lcd_hsync_n),
    .lcd_vsync_n(lcd_vsync_n),
    .lcd_de     (lcd_de),
    .pix_col    (pix_col),
    .pix_row    (pix_row),
    .lcd_red    (lcd_red),
    .lcd_grn    (lcd_grn),
    .lcd_blu    (lcd_blu)
);

// File: tb/lcd_tg_ref.sv
module lcd_tg_ref #(
    parameter int H_TOTAL      = 525,
    parameter int ROW_STEP_COL = 499,
    parameter int V_TOTAL      = 286
) (
    input  logic clk,
    input  logic rst,
    input  logic div_even,
    output int   e_col,
    output int   e_row,
    output int   e_pclk
);

    int tk = 0;

    initial begin
        e_col  = 0;
        e_row  = 0;
        e_pclk = 0;
    end

    always @(posedge clk) begin
        int period;
        int high_len;
        period   = div_even ? 12 : 11;
        high_len = div_even ? 6 : 5;
        if (rst) begin
            tk     = 0;
            e_col  = 0;
            e_row  = 0;
            e_pclk = 0;
        end else begin
            if (tk == 1) begin
                if (e_col == ROW_STEP_COL) begin
                    e_row = (e_row >= V_TOTAL - 1) ? 0 : e_row + 1;
                end
                e_col = (e_col == H_TOTAL - 1) ? 0 : e_col + 1;
            end
            if (tk == period - 1) begin
                e_pclk = 1;
            end else if (tk == high_len - 1) begin
                e_pclk = 0;
            end
            tk = (tk >= period - 1) ? 0 : tk + 1;
        end
    end

endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;

    // small raster for the second instance
    localparam int S_HT = 40, S_HA = 30, S_HSF = 32, S_HSL = 37, S_STEP = 35;
    localparam int S_VT = 12, S_VA = 8,  S_VSF = 9,  S_VSL = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic div_even = 1'b0;
    logic [5:0] r_in = '0, g_in = '0, b_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;
    bit cmp_on  = 1'b0;

    always #2 clk = ~clk;

    // full-size instance
    logic       f_pclk, f_hs, f_vs, f_de;
    logic [9:0] f_col;
    logic [8:0] f_row;
    logic [5:0] f_r, f_g, f_b;

    lcd_timing_gen u_lcd_timing_gen (
        .clk(clk), .rst(rst), .div_even(div_even),
        .red_in(r_in), .grn_in(g_in), .blu_in(b_in),
        .lcd_pclk(f_pclk), .lcd_hsync_n(f_hs), .lcd_vsync_n(f_vs), .lcd_de(f_de),
        .pix_col(f_col), .pix_row(f_row),
        .lcd_red(f_r), .lcd_grn(f_g), .lcd_blu(f_b)
    );

    // reduced raster instance
    logic       s_pclk, s_hs, s_vs, s_de;
    logic [5:0] s_col;
    logic [3:0] s_row;
    logic [5:0] s_r, s_g, s_b;

    lcd_timing_gen #(
        .H_TOTAL(S_HT), .H_ACTIVE(S_HA), .HS_FIRST(S_HSF), .HS_LAST(S_HSL),
        .ROW_STEP_COL(S_STEP), .V_TOTAL(S_VT), .V_ACTIVE(S_VA),
        .VS_FIRST(S_VSF), .VS_LAST(S_VSL)
    ) u_lcd_timing_gen_small (
        .clk(clk), .rst(rst), .div_even(div_even),
        .red_in(r_in), .grn_in(g_in), .blu_in(b_in),
        .lcd_pclk(s_pclk), .lcd_hsync_n(s_hs), .lcd_vsync_n(s_vs), .lcd_de(s_de),
        .pix_col(s_col), .pix_row(s_row),
        .lcd_red(s_r), .lcd_grn(s_g), .lcd_blu(s_b)
    );

    int fe_col, fe_row, fe_pclk;
    int se_col, se_row, se_pclk;

    lcd_tg_ref #(.H_TOTAL(525), .ROW_STEP_COL(499), .V_TOTAL(286)) u_ref_full (
        .clk(clk), .rst(rst), .div_even(div_even),
        .e_col(fe_col), .e_row(fe_row), .e_pclk(fe_pclk)
    );

    lcd_tg_ref #(.H_TOTAL(S_HT), .ROW_STEP_COL(S_STEP), .V_TOTAL(S_VT)) u_ref_small (
        .clk(clk), .rst(rst), .div_even(div_even),
        .e_col(se_col), .e_row(se_row), .e_pclk(se_pclk)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_inst(string nm, int ha, int va, int hsf, int hsl, int vsf, int vsl,
                              int e_col, int e_row, int e_pclk,
                              int a_col, int a_row, int a_pclk, int a_hs, int a_vs, int a_de,
                              int a_r, int a_g, int a_b);
        int de_exp;
        de_exp = (e_col < ha && e_row < va) ? 1 : 0;
        chk(div_even ? "R3" : "R2", {nm, " pclk"}, a_pclk, e_pclk);
        chk((e_col == 0) ? "R5" : "R4", {nm, " column"}, a_col, e_col);
        chk("R7", {nm, " row"}, a_row, e_row);
        chk("R6", {nm, " hsync"}, a_hs, (e_col >= hsf && e_col <= hsl) ? 0 : 1);
        chk("R8", {nm, " vsync"}, a_vs, (e_row >= vsf && e_row <= vsl) ? 0 : 1);
        chk("R9", {nm, " de"}, a_de, de_exp);
        chk("R10", {nm, " red"}, a_r, de_exp ? int'(r_in) : 0);
        chk("R10", {nm, " green"}, a_g, de_exp ? int'(g_in) : 0);
        chk("R10", {nm, " blue"}, a_b, de_exp ? int'(b_in) : 0);
    endtask

    task automatic drive_pix();
        r_in = 6'(cyc);
        g_in = 6'(~cyc);
        b_in = 6'(cyc * 7 + 3);
    endtask

    always @(negedge clk) begin
        cyc++;
        drive_pix();
        #1;
        if (cmp_on && !done) begin
            check_inst("full", 480, 272, 482, 523, 274, 283,
                       fe_col, fe_row, fe_pclk,
                       int'(f_col), int'(f_row), int'(f_pclk), int'(f_hs), int'(f_vs), int'(f_de),
                       int'(f_r), int'(f_g), int'(f_b));
            check_inst("small", S_HA, S_VA, S_HSF, S_HSL, S_VSF, S_VSL,
                       se_col, se_row, se_pclk,
                       int'(s_col), int'(s_row), int'(s_pclk), int'(s_hs), int'(s_vs), int'(s_de),
                       int'(s_r), int'(s_g), int'(s_b));
        end
    end

    task automatic reset_check();
        @(negedge clk);
        #1;
        chk("R1", "reset column", int'(f_col), 0);
        chk("R1", "reset row", int'(f_row), 0);
        chk("R1", "reset pclk", int'(f_pclk), 0);
        chk("R1", "reset hsync", int'(f_hs), 1);
        chk("R1", "reset vsync", int'(f_vs), 1);
        chk("R1", "reset small pclk", int'(s_pclk), 0);
    endtask

    task automatic first_edge_check(int ratio, string tag);
        // count system clocks from reset release to the first pclk rise
        int n;
        n = 0;
        while (f_pclk == 1'b0 && n < 40) begin
            @(posedge clk);
            n++;
            #1;
        end
        chk(tag, "first pclk rise delay", n, ratio);
    endtask

    initial begin
        rst = 1'b1;
        div_even = 1'b0;
        repeat (4) @(negedge clk);
        reset_check();
        cmp_on = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        first_edge_check(11, "R2");
        repeat (30000) @(negedge clk);

        rst = 1'b1;
        @(negedge clk);
        div_even = 1'b1;
        repeat (3) @(negedge clk);
        reset_check();
        @(negedge clk);
        rst = 1'b0;
        first_edge_check(12, "R3");
        repeat (30000) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule